// File: doc/BRIEF.md
# Aliased Address Watchpoint Classifier

This block listens to a processor's data-memory access bus and watches one physical word. An access reaches that word through any of the three low address segments: the user segment, the cached kernel window or the uncached kernel window. Every matching access is recorded. The block classifies it by what it did to the word. Write accesses that store zero count as clears, and the program counter of such a store places it either inside a dispatcher code window or outside it. Each record carries a timestamp, a pass number, a PC, the access direction, the data, the segment and whether some clear had already been observed. Records go into a fixed-depth buffer that is read through an index port.

Four saturating role counters run alongside the buffer. A verdict code summarises them, so one look tells whether anything ever reads the word, writes a non-zero value to it, or only zeroes it. A pass strobe marks the boundary between repetitions of a software loop. Within a pass, only the first dispatcher clear is kept in the buffer, which stops a busy loop from flooding it. Stores are sometimes reported while the PC is already one instruction ahead. For that case, a select input tags records with the PC of the previous cycle instead of the current one.

Top module: `alias_watchpoint`

## Requirements
- R1: An access matches when `effAddr[28:0]` equals the target and `effAddr[31]`=0 (segment code 0), `effAddr[31:29]`=3'b100 (code 1) or 3'b101 (code 2). Addresses with `effAddr[31:30]`=2'b11, or with any other low bits, never match.
- R2: Matching reads (`rdEn`) and writes (`wrEn`) are both recorded. An access with `isFetch` high is ignored entirely.
- R3: The role code is 0 for a zero write from inside the dispatcher window, 1 for a zero write from outside it, 2 for a non-zero write and 3 for a read. The counters `cntDispClear`, `cntOtherClear`, `cntWriter` and `cntPoller` each increment on a matching access of their own role.
- R4: The dispatcher window runs from 0xBFC4F320 to 0xBFC4F520, and both ends belong to it.
- R5: Each record holds four fields. The first is the free-running cycle count, which is 0 on the first clock edge after reset and is sampled on the clock edge that takes in the access. The others are the pass index, the tag PC and the write flag. It also holds the data, the role, the segment code, and a post-clear flag that is 1 when a clear (role 0 or 1) was recorded on an earlier cycle since reset.
- R6: The buffer holds 1024 records, and `validCount` gives the number stored. Once the buffer is full, nothing more is stored but the counters keep updating.
- R7: `passStrobe` increments the pass index on the next edge. Within one pass, only the first dispatcher clear is stored. Later dispatcher clears in that pass are counted but not stored.
- R8: `verdict` is evaluated in this priority order. It is 0 when nothing has matched and 1 when matches arrived through more than one segment. Otherwise it is 2 when a non-zero writer was seen, 3 when a reader was seen and no writer, and 4 when only clears were seen.
- R9: When `usePrevPc` is 1, the tag PC is the `pc` value of the previous cycle. That tag PC is also the one used for the dispatcher window test.
- R10: Role counters are 16 bits wide and hold at 65535 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Data read strobe |
| wrEn | input | 1 | Data write strobe |
| isFetch | input | 1 | Access is an instruction fetch |
| effAddr | input | 32 | Effective address |
| accData | input | 32 | Data written or returned |
| pc | input | 32 | Program counter seen with the access |
| passStrobe | input | 1 | Pass boundary marker |
| usePrevPc | input | 1 | Tag records with previous-cycle PC |
| rdIdx | input | 10 | Buffer read index |
| rdCycle | output | 32 | Record cycle count |
| rdPass | output | 16 | Record pass index |
| rdPc | output | 32 | Record tag PC |
| rdIsWrite | output | 1 | Record was a write |
| rdData | output | 32 | Record data |
| rdRole | output | 2 | Record role code |
| rdSeg | output | 2 | Record segment code |
| rdPostClear | output | 1 | Record post-clear flag |
| validCount | output | 11 | Number of stored records |
| cntDispClear | output | 16 | Dispatcher clear count |
| cntOtherClear | output | 16 | Other clear count |
| cntWriter | output | 16 | Non-zero writer count |
| cntPoller | output | 16 | Reader count |
| verdict | output | 3 | Verdict code |

## Verification
A wrong segment decode or window compare appears as a wrong role or segment field in the very record the access creates. It also appears on the counter for that role on the next cycle. A stuck per-pass flag only shows up at the second dispatcher clear of a pass, or at the first clear after a strobe, where `validCount` is off by one. A mistaken post-clear or alias-history bit stays hidden until a later access: it surfaces in the next record's flag or in the verdict. Counter saturation errors need more than 65535 reads before they show, so that boundary is driven in full.

// File: rtl/awp_pkg.sv
package awp_pkg;
  typedef enum logic [1:0] {
    ROLE_DISP   = 2'd0,
    ROLE_OTHER  = 2'd1,
    ROLE_WRITER = 2'd2,
    ROLE_POLLER = 2'd3
  } role_e;

  typedef enum logic [1:0] {
    SEG_USER  = 2'd0,
    SEG_K0    = 2'd1,
    SEG_K1    = 2'd2,
    SEG_OTHER = 2'd3
  } seg_e;

  typedef enum logic [2:0] {
    V_NONE    = 3'd0,
    V_ALIAS   = 3'd1,
    V_WRITER  = 3'd2,
    V_POLLED  = 3'd3,
    V_CLEARED = 3'd4
  } verdict_e;

  localparam int NUM_ROLES = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic  hit;        // matching access this cycle
    logic  store;      // write a record this cycle
    logic  isWrite;
    role_e role;
    seg_e  seg;
    logic  postClear;
  } ctrl_s;
endpackage

// File: rtl/awp_control.sv
module awp_control
  import awp_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 16,
  parameter logic [28:0] TARGET   = 29'h000_A8C8,
  parameter logic [31:0] DISP_LO  = 32'hBFC4_F320,
  parameter logic [31:0] DISP_HI  = 32'hBFC4_F520
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              isFetch,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [DATA_W-1:0] accData,
  input  logic [ADDR_W-1:0] pc,
  input  logic              passStrobe,
  input  logic              usePrevPc,
  input  logic              full,
  input  logic [CNT_W-1:0]  cntIn [NUM_ROLES],
  output ctrl_s             ctrl,
  output logic [ADDR_W-1:0] tagPc,
  output logic [2:0]        verdict
);
  logic [ADDR_W-1:0] pcPrev;
  logic              dispSeen;
  logic              clearSeen;
  logic [2:0]        segSeen;
  seg_e              seg;
  logic              addrHit;
  logic              inDisp;
  role_e             role;
  logic              hit;
  logic              anyCount;
  verdict_e          vNext;

  // segment decode
  always_comb begin
    if (!effAddr[31])                seg = SEG_USER;
    else if (effAddr[31:29] == 3'b100) seg = SEG_K0;
    else if (effAddr[31:29] == 3'b101) seg = SEG_K1;
    else                              seg = SEG_OTHER;
  end

  assign addrHit = (effAddr[28:0] == TARGET) && (seg != SEG_OTHER);
  assign hit     = (rdEn || wrEn) && !isFetch && addrHit;
  assign tagPc   = usePrevPc ? pcPrev : pc;
  assign inDisp  = (tagPc >= DISP_LO) && (tagPc <= DISP_HI);

  always_comb begin
    if (wrEn) begin
      if (accData == '0) role = inDisp ? ROLE_DISP : ROLE_OTHER;
      else               role = ROLE_WRITER;
    end else begin
      role = ROLE_POLLER;
    end
  end

  always_comb begin
    ctrl.hit       = hit;
    ctrl.isWrite   = wrEn;
    ctrl.role      = role;
    ctrl.seg       = seg;
    ctrl.postClear = clearSeen;
    ctrl.store     = hit && !full && !(role == ROLE_DISP && dispSeen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcPrev    <= '0;
      dispSeen  <= 1'b0;
      clearSeen <= 1'b0;
      segSeen   <= '0;
    end else begin
      pcPrev <= pc;
      if (passStrobe)
        dispSeen <= 1'b0;
      else if (hit && role == ROLE_DISP)
        dispSeen <= 1'b1;
      if (hit && (role == ROLE_DISP || role == ROLE_OTHER))
        clearSeen <= 1'b1;
      if (hit)
        segSeen[seg] <= 1'b1;
    end
  end

  // verdict, in priority order
  always_comb begin
    if (segSeen == '0)                  vNext = V_NONE;
    else if ($countones(segSeen) > 1)   vNext = V_ALIAS;
    else if (cntIn[ROLE_WRITER] != '0)  vNext = V_WRITER;
    else if (cntIn[ROLE_POLLER] != '0)  vNext = V_POLLED;
    else                                vNext = V_CLEARED;
  end
  assign verdict = vNext;

  assign anyCount = (cntIn[0] != '0) || (cntIn[1] != '0) ||
                    (cntIn[2] != '0) || (cntIn[3] != '0);

  // R8: counted traffic always gives a verdict other than none
  p_traffic_verdict_r8: assert property (@(posedge clk) disable iff (!rstN)
    anyCount |-> verdict != V_NONE);

  // R8: segment history never forgets a match
  p_seg_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (segSeen != '0) |=> (segSeen != '0));

  // R7: per-pass flag cleared by strobe
  p_disp_flag_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    passStrobe |=> !dispSeen);
endmodule

// File: rtl/awp_datapath.sv
module awp_datapath
  import awp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int CYC_W  = 32,
  parameter int PASS_W = 16,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int VC_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_s             ctrl,
  input  logic              passStrobe,
  input  logic [DATA_W-1:0] accData,
  input  logic [ADDR_W-1:0] tagPc,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              full,
  output logic [VC_W-1:0]   validCount,
  output logic [CNT_W-1:0]  cnt [NUM_ROLES],
  output logic [CYC_W-1:0]  rdCycle,
  output logic [PASS_W-1:0] rdPass,
  output logic [ADDR_W-1:0] rdPc,
  output logic              rdIsWrite,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        rdRole,
  output logic [1:0]        rdSeg,
  output logic              rdPostClear
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int               FLAG_W  = 6; // isWrite, role, seg, postClear

  logic [CYC_W-1:0]  cycleCnt;
  logic [PASS_W-1:0] passIdx;

  logic [CYC_W-1:0]  memCyc  [DEPTH];
  logic [PASS_W-1:0] memPass [DEPTH];
  logic [ADDR_W-1:0] memPc   [DEPTH];
  logic [DATA_W-1:0] memData [DEPTH];
  logic [FLAG_W-1:0] memFlag [DEPTH];

  logic [IDX_W-1:0] wrPtr;
  assign wrPtr = validCount[IDX_W-1:0];
  assign full  = (validCount == VC_W'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt   <= '0;
      passIdx    <= '0;
      validCount <= '0;
    end else begin
      cycleCnt <= cycleCnt + 1'b1;
      if (passStrobe) passIdx <= passIdx + 1'b1;
      if (ctrl.store) validCount <= validCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.store) begin
      memCyc[wrPtr]  <= cycleCnt;
      memPass[wrPtr] <= passIdx;
      memPc[wrPtr]   <= tagPc;
      memData[wrPtr] <= accData;
      memFlag[wrPtr] <= {ctrl.isWrite, ctrl.role, ctrl.seg, ctrl.postClear};
    end
  end

  assign rdCycle     = memCyc[rdIdx];
  assign rdPass      = memPass[rdIdx];
  assign rdPc        = memPc[rdIdx];
  assign rdData      = memData[rdIdx];
  assign rdIsWrite   = memFlag[rdIdx][5];
  assign rdRole      = memFlag[rdIdx][4:3];
  assign rdSeg       = memFlag[rdIdx][2:1];
  assign rdPostClear = memFlag[rdIdx][0];

  // one saturating counter per role
  for (genvar g = 0; g < NUM_ROLES; g++) begin : g_role_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cnt[g] <= '0;
      else if (ctrl.hit && ctrl.role == role_e'(g) && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + 1'b1;
    end

    // R10: a saturated counter stays saturated
    p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[g] == CNT_MAX) |=> (cnt[g] == CNT_MAX));
  end

  // R6: a full buffer stays full
  p_full_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    full |=> full);

  // R6: the stored count never exceeds the depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    validCount <= VC_W'(DEPTH));

  // R7: the pass index advances by one per strobe
  p_pass_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    passStrobe |=> (passIdx - $past(passIdx)) == PASS_W'(1));
endmodule

// File: rtl/alias_watchpoint.sv
module alias_watchpoint
  import awp_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          DATA_W  = 32,
  parameter int          CNT_W   = 16,
  parameter int          CYC_W   = 32,
  parameter int          PASS_W  = 16,
  parameter int          DEPTH   = 1024,
  parameter logic [28:0] TARGET  = 29'h000_A8C8,
  parameter logic [31:0] DISP_LO = 32'hBFC4_F320,
  parameter logic [31:0] DISP_HI = 32'hBFC4_F520,
  localparam int         IDX_W   = $clog2(DEPTH),
  localparam int         VC_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              isFetch,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [DATA_W-1:0] accData,
  input  logic [ADDR_W-1:0] pc,
  input  logic              passStrobe,
  input  logic              usePrevPc,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [CYC_W-1:0]  rdCycle,
  output logic [PASS_W-1:0] rdPass,
  output logic [ADDR_W-1:0] rdPc,
  output logic              rdIsWrite,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        rdRole,
  output logic [1:0]        rdSeg,
  output logic              rdPostClear,
  output logic [VC_W-1:0]   validCount,
  output logic [CNT_W-1:0]  cntDispClear,
  output logic [CNT_W-1:0]  cntOtherClear,
  output logic [CNT_W-1:0]  cntWriter,
  output logic [CNT_W-1:0]  cntPoller,
  output logic [2:0]        verdict
);
  ctrl_s             ctrl;
  logic [ADDR_W-1:0] tagPc;
  logic              full;
  logic [CNT_W-1:0]  cnt [NUM_ROLES];

  awp_control #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .TARGET(TARGET), .DISP_LO(DISP_LO), .DISP_HI(DISP_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .isFetch(isFetch),
    .effAddr(effAddr), .accData(accData), .pc(pc), .passStrobe(passStrobe),
    .usePrevPc(usePrevPc), .full(full), .cntIn(cnt), .ctrl(ctrl),
    .tagPc(tagPc), .verdict(verdict)
  );

  awp_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CYC_W(CYC_W),
    .PASS_W(PASS_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .passStrobe(passStrobe),
    .accData(accData), .tagPc(tagPc), .rdIdx(rdIdx), .full(full),
    .validCount(validCount), .cnt(cnt), .rdCycle(rdCycle), .rdPass(rdPass),
    .rdPc(rdPc), .rdIsWrite(rdIsWrite), .rdData(rdData), .rdRole(rdRole),
    .rdSeg(rdSeg), .rdPostClear(rdPostClear)
  );

  assign cntDispClear  = cnt[ROLE_DISP];
  assign cntOtherClear = cnt[ROLE_OTHER];
  assign cntWriter     = cnt[ROLE_WRITER];
  assign cntPoller     = cnt[ROLE_POLLER];
endmodule

// File: tb/alias_watchpoint_tb.sv
module alias_watchpoint_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] A_K1   = 32'hA000_A8C8;
  localparam logic [31:0] A_K0   = 32'h8000_A8C8;
  localparam logic [31:0] A_USER = 32'h0000_A8C8;
  localparam logic [31:0] A_K2   = 32'hC000_A8C8;
  localparam logic [31:0] A_NEAR = 32'hA000_A8CC;
  localparam logic [31:0] PC_OUT = 32'hBFC4_B83C;
  localparam logic [31:0] PC_IN  = 32'hBFC4_F32C;

  logic clk = 1'b0, rstN = 1'b0;
  logic rdEn = 0, wrEn = 0, isFetch = 0, passStrobe = 0, usePrevPc = 0;
  logic [31:0] effAddr = '0, accData = '0, pc = '0;
  logic [9:0]  rdIdx = '0;
  logic [31:0] rdCycle, rdPc, rdData;
  logic [15:0] rdPass, cntDispClear, cntOtherClear, cntWriter, cntPoller;
  logic        rdIsWrite, rdPostClear;
  logic [1:0]  rdRole, rdSeg;
  logic [10:0] validCount;
  logic [2:0]  verdict;

  int nChecks = 0, nFails = 0;
  logic [31:0] benchCyc;

  alias_watchpoint u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rstN)
    if (!rstN) benchCyc <= '0; else benchCyc <= benchCyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rdEn = 0; wrEn = 0; isFetch = 0; passStrobe = 0; usePrevPc = 0;
    effAddr = '0; accData = '0; pc = '0; rdIdx = '0;
    rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  // one access cycle; returns cycle value at its capturing edge
  task automatic access(input bit w, input bit r, input bit f, input logic [31:0] a,
                        input logic [31:0] d, input logic [31:0] p, output logic [31:0] cyc);
    @(negedge clk);
    wrEn = w; rdEn = r; isFetch = f; effAddr = a; accData = d; pc = p;
    cyc = benchCyc;
    @(negedge clk);
    wrEn = 0; rdEn = 0; isFetch = 0;
  endtask

  task automatic strobe();
    @(negedge clk);
    passStrobe = 1;
    @(negedge clk);
    passStrobe = 0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R6 reset validCount", validCount, 0);
    chk("R3 reset counters", cntDispClear | cntOtherClear | cntWriter | cntPoller, 0);
    chk("R8 reset verdict none", verdict, 0);
  endtask

  task automatic t_alias();
    logic [31:0] c;
    do_reset();
    access(1, 0, 0, A_K2, 0, PC_OUT, c);
    access(0, 1, 0, A_NEAR, 0, PC_OUT, c);
    chk("R1 non-matching ignored", validCount, 0);
    chk("R8 still none", verdict, 0);
    access(1, 0, 0, A_K1, 0, PC_OUT, c);
    rdIdx = 0; #1;
    chk("R1 kseg1 stored", validCount, 1);
    chk("R1 kseg1 seg code", rdSeg, 2);
    chk("R3 other clear role", rdRole, 1);
    chk("R8 only cleared", verdict, 4);
    access(1, 0, 0, A_K0, 0, PC_OUT, c);
    rdIdx = 1; #1;
    chk("R1 kseg0 seg code", rdSeg, 1);
    chk("R8 alias mismatch", verdict, 1);
    access(0, 1, 0, A_USER, 0, PC_OUT, c);
    rdIdx = 2; #1;
    chk("R1 user seg code", rdSeg, 0);
    chk("R3 poller role", rdRole, 3);
    chk("R3 other clear count", cntOtherClear, 2);
  endtask

  task automatic t_fetch();
    logic [31:0] c;
    do_reset();
    access(0, 1, 1, A_K1, 32'h5, PC_OUT, c);
    @(negedge clk);
    chk("R2 fetch not stored", validCount, 0);
    chk("R2 fetch not counted", cntPoller, 0);
    chk("R2 fetch verdict none", verdict, 0);
  endtask

  task automatic t_roles();
    logic [31:0] c;
    do_reset();
    access(0, 1, 0, A_K1, 32'h1234, PC_OUT, c);
    chk("R8 polled no writer", verdict, 3);
    access(1, 0, 0, A_K1, 32'h7, PC_OUT, c);
    rdIdx = 1; #1;
    chk("R3 writer role", rdRole, 2);
    chk("R3 writer count", cntWriter, 1);
    chk("R8 writer found", verdict, 2);
    chk("R2 write flag", rdIsWrite, 1);
    rdIdx = 0; #1;
    chk("R2 read flag", rdIsWrite, 0);
  endtask

  task automatic t_range();
    logic [31:0] c;
    do_reset();
    access(1, 0, 0, A_K1, 0, 32'hBFC4_F31C, c);
    access(1, 0, 0, A_K1, 0, 32'hBFC4_F320, c);
    strobe();
    access(1, 0, 0, A_K1, 0, 32'hBFC4_F520, c);
    access(1, 0, 0, A_K1, 0, 32'hBFC4_F524, c);
    chk("R4 four stored", validCount, 4);
    rdIdx = 0; #1; chk("R4 below window", rdRole, 1);
    rdIdx = 1; #1; chk("R4 low edge", rdRole, 0);
    rdIdx = 2; #1; chk("R4 high edge", rdRole, 0);
    rdIdx = 3; #1; chk("R4 above window", rdRole, 1);
  endtask

  task automatic t_filter_fields();
    logic [31:0] c0, c1, c2;
    do_reset();
    access(0, 1, 0, A_K1, 32'hCAFE, PC_OUT, c0);
    access(1, 0, 0, A_K1, 0, PC_IN, c1);
    access(1, 0, 0, A_K1, 0, PC_IN, c2);
    chk("R7 repeat disp not stored", validCount, 2);
    chk("R7 repeat disp counted", cntDispClear, 2);
    strobe();
    access(1, 0, 0, A_K1, 0, PC_IN, c2);
    chk("R7 new pass stores disp", validCount, 3);
    rdIdx = 0; #1;
    chk("R5 cycle", rdCycle, c0);
    chk("R5 pc", rdPc, PC_OUT);
    chk("R5 data", rdData, 32'hCAFE);
    chk("R5 no clear before", rdPostClear, 0);
    chk("R5 pass 0", rdPass, 0);
    rdIdx = 1; #1;
    chk("R5 first clear flag", rdPostClear, 0);
    chk("R5 clear cycle", rdCycle, c1);
    rdIdx = 2; #1;
    chk("R7 pass index", rdPass, 1);
    chk("R5 post clear set", rdPostClear, 1);
    chk("R5 third cycle", rdCycle, c2);
  endtask

  task automatic t_prevpc();
    logic [31:0] c;
    do_reset();
    usePrevPc = 1;
    @(negedge clk); pc = PC_IN;
    access(1, 0, 0, A_K1, 0, 32'hBFC4_D388, c);
    rdIdx = 0; #1;
    chk("R9 previous pc tagged", rdPc, PC_IN);
    chk("R9 classified by previous pc", rdRole, 0);
    usePrevPc = 0;
    @(negedge clk); pc = PC_IN;
    access(1, 0, 0, A_K1, 0, 32'hBFC4_D388, c);
    rdIdx = 1; #1;
    chk("R9 current pc tagged", rdPc, 32'hBFC4_D388);
    chk("R9 current pc role", rdRole, 1);
  endtask

  task automatic t_full_sat();
    logic [31:0] start;
    do_reset();
    @(negedge clk);
    rdEn = 1; effAddr = A_USER; accData = 0; pc = PC_OUT;
    start = benchCyc;
    for (int i = 0; i < 65540; i++) @(negedge clk);
    rdEn = 0;
    @(negedge clk);
    chk("R6 full count", validCount, 1024);
    chk("R10 saturated", cntPoller, 16'hFFFF);
    chk("R8 polled verdict", verdict, 3);
    rdIdx = 10'd1023; #1;
    chk("R6 last entry cycle", rdCycle, start + 1023);
    access(1, 0, 0, A_USER, 0, PC_OUT, start);
    chk("R6 counters run when full", cntOtherClear, 1);
    chk("R6 no store when full", validCount, 1024);
  endtask

  initial begin
    t_reset();
    t_alias();
    t_fetch();
    t_roles();
    t_range();
    t_filter_fields();
    t_prevpc();
    t_full_sat();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule